// File: doc/BRIEF.md
# Delay-Slot Branch Fetch Sequencer

This block chooses the fetch address for a seven-stage in-order pipeline and tracks whether each fetched slot is still live. The stages, in order, are instruction-cache, fetch, register-read, execute, data-cache, data-finish and writeback. Every cycle it presents one fetch address and a valid bit. It then follows that slot through the fetch, register-read and execute stages, and clears the slot's valid bit if a later redirect squashes it.

Branch information comes from two stages. The register-read stage reports unconditional jumps with their targets. The execute stage reports conditional branches with their outcome, their likely flag and their target. Jumps resolve one stage earlier than conditional branches, so a taken jump costs one bubble and a taken conditional branch costs two. In both cases the delay slot that follows still executes.

Branches that sit in another branch's delay slot follow fixed rules. These rules come from the relative timing of the two redirect points, with the execute-stage redirect taking priority. For each linking form, the block also provides the link value, which is the branch's own address plus 8.

Top module: `dslot_fetch_seq`

## Requirements
- R1: In the first cycle after reset is released, `fetch_pc` equals `RESET_VEC`, `fetch_valid` is 0, and `if_valid`, `rf_valid` and `ex_valid` are all 0. In the next cycle `RESET_VEC` is fetched with `fetch_valid` 1.
- R2: With no redirect, each cycle's `fetch_pc` is the previous cycle's `fetch_pc` plus 4. Every fetched slot moves through the IF, RF and EX stages one stage per cycle.
- R3: When a valid conditional branch in EX is taken, the next `fetch_pc` is `ex_target`. The same-cycle fetch and the slot in IF are squashed, which gives two bubbles. The delay slot in RF stays valid.
- R4: When a valid jump in RF is not overridden (see R6 and R7), the next `fetch_pc` is `rf_target` and only the same-cycle fetch is squashed, which gives one bubble. The delay slot in IF stays valid.
- R5: A valid conditional branch in EX that is not taken and not likely changes nothing. The next sequential slot runs as an ordinary instruction and no bubble is inserted.
- R6: A valid likely branch in EX that is not taken annuls the slot in RF: that slot arrives in EX with `ex_valid` 0. If the annulled slot carries a jump flag, the flag is ignored.
- R7: When an EX redirect and an RF jump fall in the same cycle, the EX target wins. A jump in a taken branch's delay slot therefore never takes effect.
- R8: Jump flags from an RF slot with `rf_valid` 0, and branch flags from an EX slot with `ex_valid` 0, have no effect on the fetch address or on any valid bit.
- R9: `rf_link` equals the address of the slot in RF plus 8, and `ex_link` equals the address of the slot in EX plus 8.
- R10: When a taken branch or jump has another taken branch or jump in its delay slot, the inner one's target is the one reached. The exception is a jump inside a conditional branch's delay slot, which follows R7. The first target's slot is squashed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_jump | input | 1 | Slot in RF is an unconditional jump |
| rf_target | input | AW | Jump target from RF |
| ex_cond | input | 1 | Slot in EX is a conditional branch |
| ex_taken | input | 1 | Conditional branch in EX is taken |
| ex_likely | input | 1 | Conditional branch in EX is the likely form |
| ex_target | input | AW | Branch target from EX |
| fetch_pc | output | AW | Address fetched this cycle |
| fetch_valid | output | 1 | This cycle's fetch is live |
| if_valid | output | 1 | Slot in IF is live |
| rf_valid | output | 1 | Slot in RF is live |
| ex_valid | output | 1 | Slot in EX is live |
| rf_link | output | AW | Link value for the slot in RF |
| ex_link | output | AW | Link value for the slot in EX |

## Verification
`fetch_valid` reacts combinationally to the RF and EX flags in the same cycle. The redirected `fetch_pc` appears one clock edge later. A squash shows up on `if_valid` and `rf_valid` one edge after the redirect, and an annul shows up on `ex_valid` one edge after the likely branch resolves. The bench keeps a behavioural slot queue that advances on the same edge. It drives flags at the falling edge from the addresses the queue holds, then compares every output shortly afterwards. Each expected value is therefore due in the same sampling window as the design's registered state. Flags are also driven for squashed slots, so the checks cover the gating of R8.

// File: rtl/dslot_pkg.sv
package dslot_pkg;
  // Stage indices of the tracked slot pipeline; order is the pipeline order.
  localparam int ST_IF   = 0;
  localparam int ST_RF   = 1;
  localparam int ST_EX   = 2;
  localparam int N_STAGE = 3;
  // Byte size of one instruction and offset of the return point.
  localparam int INSN_BYTES = 4;
  localparam int LINK_BYTES = 8;
endpackage

// File: rtl/dslot_redirect.sv
module dslot_redirect (
  input  logic rf_vld,
  input  logic rf_jump,
  input  logic ex_vld,
  input  logic ex_cond,
  input  logic ex_taken,
  input  logic ex_likely,
  output logic ex_redir,
  output logic rf_redir,
  output logic ex_annul
);
  // Only live slots may act; an annulled RF slot loses its jump.
  always_comb begin
    ex_redir = ex_vld & ex_cond & ex_taken;
    ex_annul = ex_vld & ex_cond & ~ex_taken & ex_likely;
    rf_redir = rf_vld & rf_jump & ~ex_annul;
  end
endmodule

// File: rtl/dslot_pcgen.sv
module dslot_pcgen #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_redir,
  input  logic          rf_redir,
  input  logic [AW-1:0] ex_target,
  input  logic [AW-1:0] rf_target,
  output logic [AW-1:0] fe_addr,
  output logic          fe_vld
);
  import dslot_pkg::*;

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + AW'(INSN_BYTES);
  endfunction

  logic          primed_q;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;

  // EX redirect outranks RF redirect; either one kills this cycle's fetch.
  always_comb begin
    if (ex_redir)      pc_d = ex_target;
    else if (rf_redir) pc_d = rf_target;
    else if (primed_q) pc_d = seq_next(pc_q);
    else               pc_d = pc_q;
  end

  assign fe_vld  = primed_q & ~ex_redir & ~rf_redir;
  assign fe_addr = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= RESET_VEC;
      primed_q <= 1'b0;
    end else begin
      pc_q     <= pc_d;
      primed_q <= 1'b1;
    end
  end

  a_r1_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
    !primed_q |=> (fe_addr == RESET_VEC));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    fe_vld |=> (fe_addr == $past(fe_addr) + AW'(INSN_BYTES)));
  a_r3_ex_target: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir |=> (fe_addr == $past(ex_target)));
  // R7: RF target only lands when EX is silent.
  a_r4_rf_target: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_redir && !ex_redir) |=> (fe_addr == $past(rf_target)));
endmodule

// File: rtl/dslot_slots.sv
module dslot_slots #(
  parameter int AW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [AW-1:0]                 fe_addr,
  input  logic                          fe_vld,
  input  logic [dslot_pkg::N_STAGE-1:0] kill,
  output logic [dslot_pkg::N_STAGE-1:0] vld,
  output logic [AW-1:0]                 pc [dslot_pkg::N_STAGE]
);
  import dslot_pkg::*;

  // kill[s] clears a slot as it enters stage s.
  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    logic          in_v;
    logic [AW-1:0] in_pc;
    if (s == 0) begin : g_head
      assign in_v  = fe_vld;
      assign in_pc = fe_addr;
    end else begin : g_link
      assign in_v  = vld[s-1];
      assign in_pc = pc[s-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[s] <= 1'b0;
        pc[s]  <= '0;
      end else begin
        vld[s] <= in_v & ~kill[s];
        pc[s]  <= in_pc;
      end
    end
  end
endmodule

// File: rtl/dslot_fetch_seq.sv
module dslot_fetch_seq #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = AW'(32'h0000_1000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rf_jump,
  input  logic [AW-1:0] rf_target,
  input  logic          ex_cond,
  input  logic          ex_taken,
  input  logic          ex_likely,
  input  logic [AW-1:0] ex_target,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_valid,
  output logic          if_valid,
  output logic          rf_valid,
  output logic          ex_valid,
  output logic [AW-1:0] rf_link,
  output logic [AW-1:0] ex_link
);
  import dslot_pkg::*;

  function automatic logic [AW-1:0] link_of(input logic [AW-1:0] a);
    return a + AW'(LINK_BYTES);
  endfunction

  // Named internal events, shared by the logic and the assertions.
  logic                ex_redir, rf_redir, ex_annul;
  logic [N_STAGE-1:0]  kill, vld;
  logic [AW-1:0]       spc [N_STAGE];

  dslot_redirect u_redir (
    .rf_vld(vld[ST_RF]), .rf_jump(rf_jump),
    .ex_vld(vld[ST_EX]), .ex_cond(ex_cond), .ex_taken(ex_taken),
    .ex_likely(ex_likely),
    .ex_redir(ex_redir), .rf_redir(rf_redir), .ex_annul(ex_annul)
  );

  dslot_pcgen #(.AW(AW), .RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .ex_redir(ex_redir), .rf_redir(rf_redir),
    .ex_target(ex_target), .rf_target(rf_target),
    .fe_addr(fetch_pc), .fe_vld(fetch_valid)
  );

  // Squash map: EX redirect drops the IF slot, likely-miss drops the RF slot.
  always_comb begin
    kill        = '0;
    kill[ST_RF] = ex_redir;
    kill[ST_EX] = ex_annul;
  end

  dslot_slots #(.AW(AW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .fe_addr(fetch_pc), .fe_vld(fetch_valid),
    .kill(kill), .vld(vld), .pc(spc)
  );

  assign if_valid = vld[ST_IF];
  assign rf_valid = vld[ST_RF];
  assign ex_valid = vld[ST_EX];
  assign rf_link  = link_of(spc[ST_RF]);
  assign ex_link  = link_of(spc[ST_EX]);

  a_r3_two_bubbles: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir |=> (!if_valid && !rf_valid));
  a_r3_delay_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir |=> (ex_valid == $past(rf_valid)));
  a_r4_one_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    rf_redir |=> !if_valid);
  a_r6_annul: assert property (@(posedge clk) disable iff (!rst_n)
    ex_annul |=> !ex_valid);
  a_r8_dead_rf: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_valid |-> !rf_redir);
endmodule

// File: tb/dslot_fetch_seq_tb.sv
module dslot_fetch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RV = 32'h0000_1000;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_jump = 1'b0, ex_cond = 1'b0, ex_taken = 1'b0, ex_likely = 1'b0;
  logic [31:0] rf_target = '0, ex_target = '0;
  logic [31:0] fetch_pc, rf_link, ex_link;
  logic        fetch_valid, if_valid, rf_valid, ex_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslot_fetch_seq #(.AW(32), .RESET_VEC(RV)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rf_jump(rf_jump), .rf_target(rf_target),
    .ex_cond(ex_cond), .ex_taken(ex_taken), .ex_likely(ex_likely),
    .ex_target(ex_target),
    .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
    .if_valid(if_valid), .rf_valid(rf_valid), .ex_valid(ex_valid),
    .rf_link(rf_link), .ex_link(ex_link)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Program image: 0 = ordinary, 1 = jump, 2 = conditional branch.
  int kind [WORDS];
  int tgt  [WORDS];
  bit tk   [WORDS];
  bit lk   [WORDS];

  typedef struct { logic [31:0] pc; bit v; } slot_t;
  slot_t       pipe [$];
  logic [31:0] m_pc;
  bit          m_primed;

  function automatic int widx(logic [31:0] pc);
    if (pc < RV || pc >= RV + 32'(WORDS * 4)) return -1;
    return int'((pc - RV) >> 2);
  endfunction
  function automatic logic [31:0] waddr(int i);
    return RV + 32'(i * 4);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic put_b(int at, int to, bit taken, bit likely);
    kind[at] = 2; tgt[at] = to; tk[at] = taken; lk[at] = likely;
  endtask
  task automatic put_j(int at, int to);
    kind[at] = 1; tgt[at] = to;
  endtask

  task automatic model_reset();
    m_pc = RV; m_primed = 1'b0;
    pipe.delete();
    for (int s = 0; s < 3; s++) pipe.push_back('{pc: 32'h0, v: 1'b0});
  endtask

  // One cycle: drive the stage flags, compare the outputs, advance the model.
  task automatic step();
    slot_t rs, es;
    int ri, ei;
    bit rj, ec, exr, ann, rfr, efv;
    string tag;
    rs = pipe[1]; es = pipe[2];
    ri = widx(rs.pc); ei = widx(es.pc);
    rj = (ri >= 0) && (kind[ri] == 1);
    ec = (ei >= 0) && (kind[ei] == 2);
    rf_jump   = rj;
    rf_target = rj ? waddr(tgt[ri]) : 32'h0;
    ex_cond   = ec;
    ex_taken  = ec && tk[ei];
    ex_likely = ec && lk[ei];
    ex_target = ec ? waddr(tgt[ei]) : 32'h0;
    exr = es.v && ec && tk[ei];
    ann = es.v && ec && !tk[ei] && lk[ei];
    rfr = rs.v && rj && !ann;
    efv = m_primed && !exr && !rfr;
    #1;
    if (!m_primed)                 tag = "R1";
    else if (exr && rs.v && rj)    tag = "R7";
    else if (exr && rs.v && (ri >= 0) && kind[ri] == 2) tag = "R10";
    else if (exr)                  tag = "R3";
    else if (ann)                  tag = "R6";
    else if (rfr)                  tag = "R4";
    else if ((!rs.v && rj) || (!es.v && ec)) tag = "R8";
    else if (es.v && ec)           tag = "R5";
    else                           tag = "R2";
    chk(tag, "fetch_pc", fetch_pc, m_pc);
    chk(tag, "fetch_valid", 32'(fetch_valid), 32'(efv));
    chk(tag, "if_valid", 32'(if_valid), 32'(pipe[0].v));
    chk(tag, "rf_valid", 32'(rf_valid), 32'(rs.v));
    chk(tag, "ex_valid", 32'(ex_valid), 32'(es.v));
    chk("R9", "rf_link", rf_link, rs.pc + 32'd8);
    chk("R9", "ex_link", ex_link, es.pc + 32'd8);
    // advance
    pipe.push_front('{pc: m_pc, v: efv});
    void'(pipe.pop_back());
    if (exr) pipe[1].v = 1'b0;
    if (ann) pipe[2].v = 1'b0;
    if (exr)           m_pc = waddr(tgt[ei]);
    else if (rfr)      m_pc = waddr(tgt[ri]);
    else if (m_primed) m_pc = m_pc + 32'd4;
    m_primed = 1'b1;
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      step();
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      kind[i] = 0; tgt[i] = 0; tk[i] = 1'b0; lk[i] = 1'b0;
    end
    put_b(4, 20, 1, 0);   put_j(6, 200);            // R3; squashed jump R8
    put_j(20, 40);
    put_b(40, 200, 0, 0);                           // R5
    put_b(44, 200, 0, 1); put_j(45, 100);           // R6 annulled jump
    put_b(50, 60, 1, 0);  put_b(51, 70, 1, 0);      // R10 branch in branch slot
    put_b(72, 90, 1, 0);  put_j(73, 200);           // R7
    put_j(92, 110);       put_b(93, 120, 1, 0); put_j(94, 200); // R10, R8
    put_j(122, 130);      put_j(123, 140);          // R10 jump in jump slot
    put_b(142, 150, 1, 1);                          // likely taken
    put_b(152, 160, 1, 0); put_b(153, 200, 0, 0);   // not-taken in slot
    put_j(162, 4);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run(300);
    rst_n = 1'b0;                                    // R1 again mid-run
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    run(150);
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule